// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit forms the memory address for one load or store in a 32-bit pipeline. Two address forms are supported. The displacement form adds a 16-bit signed immediate, widened by sign extension, to a base register. The indexed form adds two register values. A base register field of zero selects the constant zero in place of register 0, so the displacement form with base zero reaches the bottom 32 KB and the top 32 KB of the address space directly.

Address generation is combinational. One registered stage then presents the memory request, the illegal-form flag and the update information. Update forms return the effective address to the base register once the memory completion arrives without an exception, so a faulting access can be restarted with its base intact. The unit flags as illegal an update form with base field zero and an update load whose base field equals its destination field. An illegal operation issues no request and performs no update.

Top module: `ls_agen`

## Requirements
- R1: In the displacement form (in_form = 0), req_addr in the cycle after in_valid equals the base operand plus in_disp sign-extended to 32 bits, modulo 2^32.
- R2: In the indexed form (in_form = 1), req_addr in the cycle after in_valid equals the base operand plus in_index_val, modulo 2^32.
- R3: When in_base_idx is 0 the base operand is zero regardless of in_base_val; in_index_val is always used as given.
- R4: For a legal update operation, wb_en is high for exactly the one cycle in which cmp_valid is high with cmp_exc low, and in that cycle wb_idx equals the operation's in_base_idx and wb_data equals its effective address.
- R5: A completion with cmp_exc high produces no writeback.
- R6: An update operation (in_update = 1) with in_base_idx = 0 is illegal: in the following cycle illegal_o is high for one cycle, req_valid stays low, and the completion that follows produces no writeback.
- R7: An update load (in_is_load = 1) whose in_base_idx equals in_dest_idx is illegal in the same way as R6; an update store with equal fields is legal and writes back.
- R8: With in_base_idx = 0 in the displacement form, displacement 0x7FFF gives address 0x00007FFF and displacement 0x8000 gives 0xFFFF8000.
- R9: A non-update operation never raises wb_en, even on a clean completion.
- R10: During and right after reset, req_valid, illegal_o and wb_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Decoded operation present this cycle |
| in_is_load | input | 1 | 1 for a load, 0 for a store |
| in_form | input | 1 | 0 displacement form, 1 indexed form |
| in_update | input | 1 | Update form: write the address back to the base register |
| in_base_idx | input | 5 | Base register field |
| in_dest_idx | input | 5 | Destination (load) or source (store) register field |
| in_disp | input | 16 | Signed displacement |
| in_base_val | input | 32 | Value read for the base register |
| in_index_val | input | 32 | Value read for the index register |
| cmp_valid | input | 1 | Memory completion for the outstanding operation |
| cmp_exc | input | 1 | The completing access raised an exception |
| req_valid | output | 1 | Memory request issued (one cycle) |
| req_addr | output | 32 | Effective address |
| illegal_o | output | 1 | Illegal-form indication (one cycle) |
| wb_en | output | 1 | Base register writeback request |
| wb_idx | output | 5 | Base register to write |
| wb_data | output | 32 | Value to write (the effective address) |

## Verification
The assertions take for granted that at most one operation is outstanding: each in_valid pulse is followed by its cmp_valid pulse before the next operation arrives, and the two never share a cycle. Completions are single-cycle pulses, and cmp_exc means nothing outside them. The bench drives operations and completions through separate tasks that each raise the signal for one cycle and then wait for the next task, so the stimulus never overlaps two operations.

// File: rtl/ls_agen_pkg.sv
package ls_agen_pkg;
   typedef enum logic {
      FORM_DISP  = 1'b0,
      FORM_INDEX = 1'b1
   } ea_form_e;
endpackage

// File: rtl/ls_agen_operand.sv
// Effective address adder with zero-base rule and displacement widening.
module ls_agen_operand
   import ls_agen_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int DISP_W = 16,
   parameter int REG_AW = 5
) (
   input  ea_form_e          form,
   input  logic [REG_AW-1:0] base_idx,
   input  logic [DISP_W-1:0] disp,
   input  logic [XLEN-1:0]   base_val,
   input  logic [XLEN-1:0]   index_val,
   output logic [XLEN-1:0]   ea
);
   localparam int EXT_W = XLEN - DISP_W;

   logic [XLEN-1:0] disp_wide;
   logic [XLEN-1:0] base_op;
   logic [XLEN-1:0] off_op;

   generate
      if (EXT_W == 0) begin : g_no_ext
         assign disp_wide = disp;
      end else begin : g_sext
         assign disp_wide = {{EXT_W{disp[DISP_W-1]}}, disp};
      end
   endgenerate

   always_comb begin
      base_op = (base_idx == '0) ? '0 : base_val;
      off_op  = (form == FORM_INDEX) ? index_val : disp_wide;
      ea      = base_op + off_op;
   end
endmodule

// File: rtl/ls_agen_legal.sv
// Detects update forms whose register fields conflict.
module ls_agen_legal #(
   parameter int REG_AW = 5
) (
   input  logic              update,
   input  logic              is_load,
   input  logic [REG_AW-1:0] base_idx,
   input  logic [REG_AW-1:0] dest_idx,
   output logic              illegal
);
   logic zero_base;
   logic load_clash;

   always_comb begin
      zero_base  = (base_idx == '0);
      load_clash = is_load && (base_idx == dest_idx);
      illegal    = update && (zero_base || load_clash);
   end
endmodule

// File: rtl/ls_agen_stage.sv
// Output register stage and pending update bookkeeping for one access.
module ls_agen_stage #(
   parameter int XLEN   = 32,
   parameter int REG_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              illegal,
   input  logic              update,
   input  logic [REG_AW-1:0] base_idx,
   input  logic [XLEN-1:0]   ea,
   input  logic              cmp_valid,
   input  logic              cmp_exc,
   output logic              req_valid,
   output logic [XLEN-1:0]   req_addr,
   output logic              illegal_o,
   output logic              wb_en,
   output logic [REG_AW-1:0] wb_idx,
   output logic [XLEN-1:0]   wb_data
);
   logic              req_q;
   logic              ill_q;
   logic              pend_q;
   logic              upd_q;
   logic [REG_AW-1:0] idx_q;
   logic [XLEN-1:0]   addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         ill_q  <= 1'b0;
         pend_q <= 1'b0;
         upd_q  <= 1'b0;
         idx_q  <= '0;
         addr_q <= '0;
      end else if (in_valid) begin
         req_q  <= !illegal;
         ill_q  <= illegal;
         pend_q <= !illegal;
         upd_q  <= update;
         idx_q  <= base_idx;
         addr_q <= ea;
      end else begin
         req_q <= 1'b0;
         ill_q <= 1'b0;
         if (cmp_valid) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign req_valid = req_q;
   assign req_addr  = addr_q;
   assign illegal_o = ill_q;
   assign wb_en     = cmp_valid && !cmp_exc && pend_q && upd_q;
   assign wb_idx    = idx_q;
   assign wb_data   = addr_q;
endmodule

// File: rtl/ls_agen.sv
module ls_agen
   import ls_agen_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int DISP_W = 16,
   parameter int REG_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_is_load,
   input  logic              in_form,
   input  logic              in_update,
   input  logic [REG_AW-1:0] in_base_idx,
   input  logic [REG_AW-1:0] in_dest_idx,
   input  logic [DISP_W-1:0] in_disp,
   input  logic [XLEN-1:0]   in_base_val,
   input  logic [XLEN-1:0]   in_index_val,
   input  logic              cmp_valid,
   input  logic              cmp_exc,
   output logic              req_valid,
   output logic [XLEN-1:0]   req_addr,
   output logic              illegal_o,
   output logic              wb_en,
   output logic [REG_AW-1:0] wb_idx,
   output logic [XLEN-1:0]   wb_data
);
   generate
      if (DISP_W < 2 || DISP_W > XLEN) begin : g_bad_disp
         $error("ls_agen: DISP_W must lie in 2..XLEN");
      end
      if (REG_AW < 1) begin : g_bad_reg
         $error("ls_agen: REG_AW must be at least 1");
      end
   endgenerate

   logic [XLEN-1:0] ea;
   logic            illegal;
   ea_form_e        form;

   assign form = ea_form_e'(in_form);

   ls_agen_operand #(.XLEN(XLEN), .DISP_W(DISP_W), .REG_AW(REG_AW)) u_operand (
      .form      (form),
      .base_idx  (in_base_idx),
      .disp      (in_disp),
      .base_val  (in_base_val),
      .index_val (in_index_val),
      .ea        (ea)
   );

   ls_agen_legal #(.REG_AW(REG_AW)) u_legal (
      .update   (in_update),
      .is_load  (in_is_load),
      .base_idx (in_base_idx),
      .dest_idx (in_dest_idx),
      .illegal  (illegal)
   );

   ls_agen_stage #(.XLEN(XLEN), .REG_AW(REG_AW)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .illegal   (illegal),
      .update    (in_update),
      .base_idx  (in_base_idx),
      .ea        (ea),
      .cmp_valid (cmp_valid),
      .cmp_exc   (cmp_exc),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .illegal_o (illegal_o),
      .wb_en     (wb_en),
      .wb_idx    (wb_idx),
      .wb_data   (wb_data)
   );
endmodule

// File: rtl/ls_agen_chk.sv
module ls_agen_chk #(
   parameter int XLEN   = 32,
   parameter int DISP_W = 16,
   parameter int REG_AW = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_is_load,
   input logic              in_form,
   input logic              in_update,
   input logic [REG_AW-1:0] in_base_idx,
   input logic [REG_AW-1:0] in_dest_idx,
   input logic [DISP_W-1:0] in_disp,
   input logic [XLEN-1:0]   in_base_val,
   input logic [XLEN-1:0]   in_index_val,
   input logic              cmp_valid,
   input logic              cmp_exc,
   input logic              req_valid,
   input logic [XLEN-1:0]   req_addr,
   input logic              illegal_o,
   input logic              wb_en,
   input logic [REG_AW-1:0] wb_idx,
   input logic [XLEN-1:0]   wb_data
);
   logic [XLEN-1:0] base_op;
   logic [XLEN-1:0] disp_ext;
   assign base_op  = (in_base_idx == '0) ? '0 : in_base_val;
   assign disp_ext = XLEN'($signed(in_disp));

   p_disp_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_form |=> req_addr == $past(base_op) + $past(disp_ext));

   p_index_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_form |=> req_addr == $past(base_op) + $past(in_index_val));

   p_wb_clean_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> cmp_valid && wb_data == req_addr);

   p_wb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |=> !wb_en);

   p_no_wb_on_exc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_exc |-> !wb_en);

   p_zero_base_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_update && in_base_idx == '0 |=> illegal_o && !req_valid);

   p_load_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_update && in_is_load && in_base_idx == in_dest_idx
      |=> illegal_o && !req_valid);

   p_illegal_blocks_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(illegal_o && req_valid));

   p_no_upd_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_update |=> !wb_en);

   p_wb_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_update |=> wb_idx == $past(in_base_idx));
endmodule

bind ls_agen ls_agen_chk #(.XLEN(XLEN), .DISP_W(DISP_W), .REG_AW(REG_AW)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_is_load   (in_is_load),
   .in_form      (in_form),
   .in_update    (in_update),
   .in_base_idx  (in_base_idx),
   .in_dest_idx  (in_dest_idx),
   .in_disp      (in_disp),
   .in_base_val  (in_base_val),
   .in_index_val (in_index_val),
   .cmp_valid    (cmp_valid),
   .cmp_exc      (cmp_exc),
   .req_valid    (req_valid),
   .req_addr     (req_addr),
   .illegal_o    (illegal_o),
   .wb_en        (wb_en),
   .wb_idx       (wb_idx),
   .wb_data      (wb_data)
);

// File: tb/ls_agen_tb_top.sv
module ls_agen_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_is_load = 1'b0, in_form = 1'b0, in_update = 1'b0;
   logic [4:0]  in_base_idx = '0, in_dest_idx = '0;
   logic [15:0] in_disp = '0;
   logic [31:0] in_base_val = '0, in_index_val = '0;
   logic        cmp_valid = 1'b0, cmp_exc = 1'b0;
   logic        req_valid, illegal_o, wb_en;
   logic [31:0] req_addr, wb_data;
   logic [4:0]  wb_idx;

   int    checks = 0;
   int    errors = 0;
   string tag = "R10";
   bit    done = 1'b0;

   // reference model state
   bit          m_req, m_ill, m_pend, m_upd;
   logic [4:0]  m_idx;
   logic [31:0] m_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   ls_agen dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_load(in_is_load),
      .in_form(in_form), .in_update(in_update), .in_base_idx(in_base_idx),
      .in_dest_idx(in_dest_idx), .in_disp(in_disp), .in_base_val(in_base_val),
      .in_index_val(in_index_val), .cmp_valid(cmp_valid), .cmp_exc(cmp_exc),
      .req_valid(req_valid), .req_addr(req_addr), .illegal_o(illegal_o),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
   );

   function automatic logic [31:0] ref_ea();
      logic [31:0] b;
      b = (in_base_idx == 0) ? 32'h0 : in_base_val;
      return in_form ? b + in_index_val : b + {{16{in_disp[15]}}, in_disp};
   endfunction

   function automatic bit ref_illegal();
      return in_update && (in_base_idx == 0 || (in_is_load && in_base_idx == in_dest_idx));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_req = 0; m_ill = 0; m_pend = 0; m_upd = 0; m_idx = '0; m_addr = '0;
      end else if (in_valid) begin
         m_req  = !ref_illegal();
         m_ill  = ref_illegal();
         m_pend = !ref_illegal();
         m_upd  = in_update;
         m_idx  = in_base_idx;
         m_addr = ref_ea();
      end else begin
         m_req = 0; m_ill = 0;
         if (cmp_valid) m_pend = 0;
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // compare on every falling edge
   always @(negedge clk) begin
      if (!done) begin
         bit e_wb;
         e_wb = cmp_valid && !cmp_exc && m_pend && m_upd;
         chk("req_valid", 32'(req_valid), 32'(m_req));
         chk("illegal_o", 32'(illegal_o), 32'(m_ill));
         chk("wb_en", 32'(wb_en), 32'(e_wb));
         if (m_req || m_ill) chk("req_addr", req_addr, m_addr);
         if (e_wb) begin
            chk("wb_idx", 32'(wb_idx), 32'(m_idx));
            chk("wb_data", wb_data, m_addr);
         end
      end
   end

   task automatic op(input string t, input bit form, input bit load, input bit upd,
                     input logic [4:0] b, input logic [4:0] d, input logic [15:0] disp,
                     input logic [31:0] bv, input logic [31:0] xv);
      @(posedge clk); #1;
      tag = t;
      in_valid = 1; in_form = form; in_is_load = load; in_update = upd;
      in_base_idx = b; in_dest_idx = d; in_disp = disp;
      in_base_val = bv; in_index_val = xv;
      @(posedge clk); #1;
      in_valid = 0;
   endtask

   task automatic complete(input bit exc);
      @(posedge clk); #1;
      cmp_valid = 1; cmp_exc = exc;
      @(posedge clk); #1;
      cmp_valid = 0; cmp_exc = 0;
      @(posedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      tag = "R10";
      chk("reset req_valid", 32'(req_valid), 0);
      chk("reset illegal_o", 32'(illegal_o), 0);
      chk("reset wb_en", 32'(wb_en), 0);
      rst_n = 1;
      repeat (2) @(posedge clk);

      op("R1 disp positive", 0, 1, 0, 5'd3, 5'd4, 16'h0010, 32'h0000_1000, 32'hDEAD_0000);
      complete(0);
      op("R1 disp negative", 0, 0, 0, 5'd7, 5'd4, 16'hFFF0, 32'h0000_1000, 32'h0);
      complete(0);
      op("R1 disp wrap", 0, 1, 0, 5'd9, 5'd1, 16'h0008, 32'hFFFF_FFFC, 32'h0);
      complete(0);
      op("R2 indexed", 1, 1, 0, 5'd6, 5'd2, 16'h7777, 32'h1234_0000, 32'h0000_5678);
      complete(0);
      op("R3 indexed base zero", 1, 1, 0, 5'd0, 5'd2, 16'h0, 32'hFFFF_FFFF, 32'h0000_0ABC);
      complete(0);
      op("R3 disp base zero", 0, 0, 0, 5'd0, 5'd2, 16'h0100, 32'h5555_5555, 32'h0);
      complete(0);
      op("R8 low window", 0, 1, 0, 5'd0, 5'd2, 16'h7FFF, 32'h9999_9999, 32'h0);
      complete(0);
      op("R8 high window", 0, 1, 0, 5'd0, 5'd2, 16'h8000, 32'h9999_9999, 32'h0);
      complete(0);
      op("R4 update load", 0, 1, 1, 5'd12, 5'd13, 16'h0004, 32'h0002_0000, 32'h0);
      complete(0);
      op("R4 update indexed store", 1, 0, 1, 5'd1, 5'd30, 16'h0, 32'h0000_4000, 32'h0000_0040);
      complete(0);
      op("R5 update with exception", 0, 1, 1, 5'd12, 5'd13, 16'h0008, 32'h0002_0000, 32'h0);
      complete(1);
      op("R6 update base zero", 0, 1, 1, 5'd0, 5'd5, 16'h0010, 32'h0, 32'h0);
      complete(0);
      op("R6 update store base zero", 1, 0, 1, 5'd0, 5'd5, 16'h0, 32'h0, 32'h10);
      complete(0);
      op("R7 update load clash", 0, 1, 1, 5'd8, 5'd8, 16'h0020, 32'h0000_3000, 32'h0);
      complete(0);
      op("R7 update store same field", 0, 0, 1, 5'd8, 5'd8, 16'h0020, 32'h0000_3000, 32'h0);
      complete(0);
      op("R9 plain load", 1, 1, 0, 5'd4, 5'd9, 16'h0, 32'h0000_0100, 32'h0000_0004);
      complete(0);

      // explicit port-level checks on the update decisions
      tag = "R4";
      op("R4 direct", 0, 1, 1, 5'd20, 5'd21, 16'hFFFC, 32'h0000_8000, 32'h0);
      @(posedge clk); #1; cmp_valid = 1;
      @(negedge clk);
      chk("R4 wb_en high", 32'(wb_en), 1);
      chk("R4 wb_idx", 32'(wb_idx), 32'd20);
      chk("R4 wb_data", wb_data, 32'h0000_7FFC);
      @(posedge clk); #1; cmp_valid = 0;
      @(negedge clk);
      chk("R4 wb_en one cycle", 32'(wb_en), 0);

      tag = "R9";
      op("R9 direct", 0, 0, 0, 5'd20, 5'd21, 16'h0004, 32'h0000_8000, 32'h0);
      @(posedge clk); #1; cmp_valid = 1;
      @(negedge clk);
      chk("R9 no wb", 32'(wb_en), 0);
      @(posedge clk); #1; cmp_valid = 0;

      repeat (3) @(posedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule